// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Port

This block is the host-facing side of a dot-matrix display controller. A microcontroller talks to it over an 8-bit parallel bus using either of two common conventions: a single enable line qualified by a read/write direction line, or two separate active-low strobes, one for read and one for write. The level on the reset pin picks the convention. A register-select line sends each access either to the instruction path or to the display-data path.

All host strobes are brought into the core clock through synchronizers. A state machine turns each write into a single-cycle pulse for the command decoder or for the RAM controller, with the captured byte alongside it. A read returns a packed status byte when register-select is low. When register-select is high, it returns the byte fetched by the previous display read. Each display read then starts a new fetch, so the first read after an address change is a dummy read. The block drives the data bus only while a read is in progress.

State machine: `ST_IDLE` waits for a strobe. `ST_IDLE -> ST_READ` happens on a read start, and `ST_IDLE -> ST_WRITE` on a write start. `ST_READ` drives the bus. `ST_READ -> ST_PREFETCH` happens when a display read ends, and `ST_READ -> ST_IDLE` when a status read ends. `ST_WRITE -> ST_ISSUE` happens when the write strobe ends. `ST_ISSUE` emits the write pulse and then goes to `ST_IDLE`. `ST_PREFETCH` requests a RAM byte and then goes to `ST_CAPTURE`. `ST_CAPTURE` latches the byte and then goes to `ST_IDLE`. A host reset pulse sends any state to `ST_IDLE`.

Top module: `hostport_if`

## Requirements
- R1: After each change of the synchronized reset-pin level, `mode68` equals that level. A value of 1 selects enable-plus-direction mode and 0 selects separate-strobe mode. After core reset, with the pin held low, `mode68` is 0.
- R2: Every change of the synchronized reset-pin level produces exactly one single-cycle `host_reset` pulse. An access in progress is abandoned.
- R3: In enable mode (`mode68`=1), a write is an `en_rd_n` high period with `rw_wr_n` low. It produces one write pulse, carrying the byte held on `db_in` at the end of the enable period.
- R4: In strobe mode (`mode68`=0), a write is a low period on `rw_wr_n`. It produces one write pulse after the strobe rises, carrying the byte present at the rising edge.
- R5: A write with `rs`=0 pulses `cmd_wr` and a write with `rs`=1 pulses `dat_wr`. The two never pulse together, and each pulse lasts one cycle with `wr_byte` valid.
- R6: A read with `rs`=0 returns the status byte. Bit 7 is busy (1 = internal processing), bit 6 is segment direction (1 = forward), bit 5 is display-off (1 = off), bit 4 is reset-in-progress (1 = resetting), and bits 3..0 read 0.
- R7: A read with `rs`=1 returns the byte latched by the previous display read. After core reset this byte is 0. Once the read ends, exactly one single-cycle `ram_rd_req` pulse is issued, and the `ram_rd_data` value one cycle later becomes the next latched byte.
- R8: `db_oe` is 1 only while a read access is active. It is 0 during writes and when the bus is idle.
- R9: A status read issues no `ram_rd_req` and leaves the latched display byte unchanged.
- R10: In enable mode, toggling `rw_wr_n` while `en_rd_n` is low produces no write pulse and does not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Core reset, active low |
| rsel_pin | input | 1 | Host reset pin; its level selects the bus convention |
| rs | input | 1 | Register select: 1 display data, 0 instruction |
| en_rd_n | input | 1 | Enable (enable mode) or read strobe, active low (strobe mode) |
| rw_wr_n | input | 1 | Direction, 1 = read (enable mode), or write strobe, active low (strobe mode) |
| db_in | input | 8 | Data bus value from the host |
| db_out | output | 8 | Data driven toward the host |
| db_oe | output | 1 | Output enable for the data bus pads |
| st_busy | input | 1 | Busy flag from the core |
| st_adc | input | 1 | Segment direction flag, 1 = forward |
| st_off | input | 1 | Display-off flag |
| st_reset | input | 1 | Reset-in-progress flag |
| ram_rd_data | input | 8 | Display RAM byte, valid one cycle after the request |
| ram_rd_req | output | 1 | Single-cycle display RAM fetch request |
| cmd_wr | output | 1 | Single-cycle instruction write pulse |
| dat_wr | output | 1 | Single-cycle display data write pulse |
| wr_byte | output | 8 | Byte that goes with the write pulses |
| host_reset | output | 1 | Single-cycle pulse on a reset-pin level change |
| mode68 | output | 1 | 1 = enable-plus-direction mode, 0 = separate-strobe mode |

## Verification
The hardest case to reach is the handover between conventions. When the reset pin flips, the idle line levels of one convention look like an active read in the other, so a spurious access starts in the same window as the host reset pulse. The stimulus flips the pin with register-select held low. It then lets the spurious status read run out, and checks that the pulse count, the mode and the fetch count all remain correct. A chain of display reads through both conventions then confirms that the latched byte stays one access behind the RAM fetches.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_ISSUE,
        ST_PREFETCH,
        ST_CAPTURE
    } hp_state_t;

    localparam int FLAG_COUNT = 4;
endpackage

// File: rtl/hostport_sync.sv
module hostport_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[g] <= RST_VAL;
                end else begin
                    if (g == 0) pipe[g] <= d;
                    else        pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hostport_modesel.sv
module hostport_modesel (
    input  logic clk,
    input  logic rst_n,
    input  logic rsel_s,
    output logic mode68,
    output logic host_reset
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q    <= 1'b0;
            host_reset <= 1'b0;
        end else begin
            host_reset <= (rsel_s != level_q);
            level_q    <= rsel_s;
        end
    end

    assign mode68 = level_q;

    assert_mode_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode68) |-> host_reset);

    assert_reset_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_reset |=> !host_reset || !$stable(mode68));
endmodule

// File: rtl/hostport_fsm.sv
module hostport_fsm
    import hostport_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          mode68,
    input  logic          strb_s,
    input  logic          dir_s,
    input  logic          rs,
    input  logic [DW-1:0] db_in,
    input  logic [DW-1:0] ram_rd_data,
    output logic          cmd_wr,
    output logic          dat_wr,
    output logic [DW-1:0] wr_byte,
    output logic          rd_req,
    output logic          drive,
    output logic          sel_data,
    output logic [DW-1:0] rd_latch
);
    hp_state_t state, state_nx;
    logic      rs_q;
    logic      rd_on, wr_on, rd_hold, wr_hold;

    // start and hold conditions for both bus conventions
    assign rd_on   = mode68 ? (strb_s & dir_s)  : ~strb_s;
    assign wr_on   = mode68 ? (strb_s & ~dir_s) : ~dir_s;
    assign rd_hold = mode68 ? strb_s : ~strb_s;
    assign wr_hold = mode68 ? strb_s : ~dir_s;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (rd_on)         state_nx = ST_READ;
                         else if (wr_on)    state_nx = ST_WRITE;
            ST_READ:     if (!rd_hold)      state_nx = rs_q ? ST_PREFETCH : ST_IDLE;
            ST_WRITE:    if (!wr_hold)      state_nx = ST_ISSUE;
            ST_ISSUE:                       state_nx = ST_IDLE;
            ST_PREFETCH:                    state_nx = ST_CAPTURE;
            ST_CAPTURE:                     state_nx = ST_IDLE;
            default:                        state_nx = ST_IDLE;
        endcase
        if (flush) state_nx = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q     <= 1'b0;
            wr_byte  <= '0;
            rd_latch <= '0;
        end else begin
            if (state == ST_IDLE && (rd_on || wr_on)) rs_q <= rs;
            if (state == ST_WRITE && wr_hold)         wr_byte <= db_in;
            if (state == ST_CAPTURE)                  rd_latch <= ram_rd_data;
        end
    end

    always_comb begin
        cmd_wr   = 1'b0;
        dat_wr   = 1'b0;
        rd_req   = 1'b0;
        drive    = 1'b0;
        unique case (state)
            ST_ISSUE:    begin cmd_wr = ~rs_q; dat_wr = rs_q; end
            ST_PREFETCH: rd_req = 1'b1;
            ST_READ:     drive  = 1'b1;
            default:     ;
        endcase
    end
    assign sel_data = rs_q;

    assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_wr && dat_wr));

    assert_write_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr || dat_wr) |=> !(cmd_wr || dat_wr));

    assert_fetch_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req && $stable(rd_latch));

    assert_no_drive_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> !cmd_wr && !dat_wr && !rd_req);

    assert_status_keeps_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && !sel_data) |=> $stable(rd_latch));
endmodule

// File: rtl/hostport_if.sv
module hostport_if
    import hostport_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rsel_pin,
    input  logic          rs,
    input  logic          en_rd_n,
    input  logic          rw_wr_n,
    input  logic [DW-1:0] db_in,
    output logic [DW-1:0] db_out,
    output logic          db_oe,
    input  logic          st_busy,
    input  logic          st_adc,
    input  logic          st_off,
    input  logic          st_reset,
    input  logic [DW-1:0] ram_rd_data,
    output logic          ram_rd_req,
    output logic          cmd_wr,
    output logic          dat_wr,
    output logic [DW-1:0] wr_byte,
    output logic          host_reset,
    output logic          mode68
);
    localparam int PAD_BITS = DW - FLAG_COUNT;

    logic [2:0]    sync_q;
    logic          drive, sel_data;
    logic [DW-1:0] rd_latch, status_byte;

    hostport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rsel_pin, en_rd_n, rw_wr_n}),
        .q     (sync_q)
    );

    hostport_modesel u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsel_s     (sync_q[2]),
        .mode68     (mode68),
        .host_reset (host_reset)
    );

    hostport_fsm #(.DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (host_reset),
        .mode68      (mode68),
        .strb_s      (sync_q[1]),
        .dir_s       (sync_q[0]),
        .rs          (rs),
        .db_in       (db_in),
        .ram_rd_data (ram_rd_data),
        .cmd_wr      (cmd_wr),
        .dat_wr      (dat_wr),
        .wr_byte     (wr_byte),
        .rd_req      (ram_rd_req),
        .drive       (drive),
        .sel_data    (sel_data),
        .rd_latch    (rd_latch)
    );

    assign status_byte = {st_busy, st_adc, st_off, st_reset, {PAD_BITS{1'b0}}};
    assign db_oe  = drive;
    assign db_out = drive ? (sel_data ? rd_latch : status_byte) : '0;

    assert_oe_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr || dat_wr || host_reset) |-> !db_oe);
endmodule

// File: tb/hostport_if_tb_top.sv
module hostport_if_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rsel_pin = 1'b0, rs = 1'b0, en_rd_n = 1'b1, rw_wr_n = 1'b1;
    logic [7:0] db_in = '0, db_out, ram_rd_data, wr_byte;
    logic       db_oe, st_busy = 0, st_adc = 0, st_off = 0, st_reset = 0;
    logic       ram_rd_req, cmd_wr, dat_wr, host_reset, mode68;

    int n_chk = 0, n_bad = 0;
    int cmd_cnt = 0, dat_cnt = 0, rdq_cnt = 0, hr_cnt = 0;
    logic [7:0] last_wbyte = '0, next_ram = 8'h3C, exp_latch = '0;
    bit m68 = 0;

    always #2 clk = ~clk;

    hostport_if dut_i (
        .clk(clk), .rst_n(rst_n), .rsel_pin(rsel_pin), .rs(rs),
        .en_rd_n(en_rd_n), .rw_wr_n(rw_wr_n), .db_in(db_in),
        .db_out(db_out), .db_oe(db_oe), .st_busy(st_busy), .st_adc(st_adc),
        .st_off(st_off), .st_reset(st_reset), .ram_rd_data(ram_rd_data),
        .ram_rd_req(ram_rd_req), .cmd_wr(cmd_wr), .dat_wr(dat_wr),
        .wr_byte(wr_byte), .host_reset(host_reset), .mode68(mode68)
    );

    // RAM model and pulse monitors
    always @(posedge clk) begin
        if (!rst_n) begin
            ram_rd_data <= 8'h00;
        end else begin
            if (ram_rd_req) begin
                ram_rd_data <= next_ram;
                next_ram    <= next_ram + 8'h17;
                rdq_cnt     <= rdq_cnt + 1;
            end
            if (cmd_wr) begin cmd_cnt <= cmd_cnt + 1; last_wbyte <= wr_byte; end
            if (dat_wr) begin dat_cnt <= dat_cnt + 1; last_wbyte <= wr_byte; end
            if (host_reset) hr_cnt <= hr_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic r, input logic [7:0] b);
        rs = r; db_in = b;
        if (m68) begin
            rw_wr_n = 0; cyc(1); en_rd_n = 1; cyc(6);
            check(db_oe == 0, "R8 oe during write", db_oe, 0);
            en_rd_n = 0; cyc(6); rw_wr_n = 1;
        end else begin
            rw_wr_n = 0; cyc(6);
            check(db_oe == 0, "R8 oe during write", db_oe, 0);
            rw_wr_n = 1; cyc(6);
        end
        cyc(2);
    endtask

    task automatic bus_rd(input logic r, output logic [7:0] got, output logic oe);
        rs = r;
        if (m68) begin rw_wr_n = 1; en_rd_n = 1; end
        else     en_rd_n = 0;
        cyc(6);
        got = db_out; oe = db_oe;
        en_rd_n = m68 ? 1'b0 : 1'b1;
        cyc(8);
    endtask

    task automatic t_reset_state;
        check(mode68 == 0, "R1 reset mode", mode68, 0);
        check(db_oe == 0, "R8 reset oe", db_oe, 0);
        check(hr_cnt == 0, "R2 no pulse at reset", hr_cnt, 0);
    endtask

    task automatic t_write(input logic r, input logic [7:0] b, input string tag);
        int c0 = cmd_cnt, d0 = dat_cnt;
        bus_wr(r, b);
        check(cmd_cnt == c0 + (r ? 0 : 1), {tag, " R5 cmd count"}, cmd_cnt - c0, r ? 0 : 1);
        check(dat_cnt == d0 + (r ? 1 : 0), {tag, " R5 dat count"}, dat_cnt - d0, r ? 1 : 0);
        check(last_wbyte == b, {tag, " byte"}, last_wbyte, b);
    endtask

    task automatic t_status(input logic [3:0] f, input string tag);
        logic [7:0] got; logic oe; int q0 = rdq_cnt;
        {st_busy, st_adc, st_off, st_reset} = f;
        bus_rd(1'b0, got, oe);
        check(oe == 1, {tag, " R8 oe in read"}, oe, 1);
        check(got == {f, 4'h0}, {tag, " R6 status"}, got, {f, 4'h0});
        check(rdq_cnt == q0, {tag, " R9 no fetch"}, rdq_cnt - q0, 0);
        cyc(1);
        check(db_oe == 0, {tag, " R8 oe after read"}, db_oe, 0);
    endtask

    task automatic t_data_read(input string tag);
        logic [7:0] got; logic oe; int q0 = rdq_cnt;
        bus_rd(1'b1, got, oe);
        check(got == exp_latch, {tag, " R7 pipelined byte"}, got, exp_latch);
        check(rdq_cnt == q0 + 1, {tag, " R7 one fetch"}, rdq_cnt - q0, 1);
        exp_latch = ram_rd_data;
    endtask

    task automatic t_switch(input logic lvl);
        int h0 = hr_cnt, q0 = rdq_cnt;
        rs = 0; rsel_pin = lvl; cyc(5);
        m68 = lvl;
        en_rd_n = lvl ? 1'b0 : 1'b1; rw_wr_n = 1; cyc(10);
        check(hr_cnt == h0 + 1, "R2 one reset pulse", hr_cnt - h0, 1);
        check(mode68 == lvl, "R1 mode follows pin", mode68, lvl);
        check(rdq_cnt == q0, "R9 no fetch on switch", rdq_cnt - q0, 0);
    endtask

    task automatic t_ignore68;
        int c0 = cmd_cnt, d0 = dat_cnt;
        repeat (3) begin
            rw_wr_n = 0; cyc(5);
            check(db_oe == 0, "R10 no drive", db_oe, 0);
            rw_wr_n = 1; cyc(5);
        end
        check(cmd_cnt == c0 && dat_cnt == d0, "R10 no write", cmd_cnt + dat_cnt - c0 - d0, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(4); rst_n = 1; cyc(6);
        t_reset_state();
        // strobe mode
        t_write(1'b0, 8'hA5, "R4 strobe cmd");
        t_write(1'b1, 8'h3E, "R4 strobe data");
        t_status(4'b1010, "s80 a");
        t_status(4'b0101, "s80 b");
        t_data_read("s80 first (dummy)");
        t_status(4'b1111, "s80 between");
        t_data_read("s80 second");
        t_data_read("s80 third");
        // enable mode
        t_switch(1'b1);
        t_write(1'b0, 8'h81, "R3 enable cmd");
        t_write(1'b1, 8'h7F, "R3 enable data");
        t_status(4'b0011, "s68");
        t_data_read("s68 a");
        t_data_read("s68 b");
        t_ignore68();
        // back to strobe mode
        t_switch(1'b0);
        t_write(1'b1, 8'h00, "R4 after switch");
        t_data_read("s80 after switch");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule